// File: doc/BRIEF.md
# Accumulator Word Extract Unit

This unit holds four 64-bit accumulators and pulls a 32-bit word out of any one of them on request. The chosen accumulator is shifted right arithmetically by an amount that is set at run time. The word is then taken as it is, rounded, or rounded and clamped. The 32-bit word leaves the unit sign-extended to 64 bits. A sticky flag in a 32-bit control register records every overflow or clamp.

An extract is requested by raising `ext_valid` together with the accumulator select, the shift-source value and the variant. The result and the flag update appear one clock later, marked by `res_valid`. The accumulators are loaded through a separate write port, and an extract never changes them. If a write and an extract happen in the same cycle, the extract sees the value from before the write.

Top module: `acc_word_extract`

## Requirements
- R1: The shift amount is `shift_src[4:0]` (0 to 31). Bits 63:5 of `shift_src` have no effect on the result or on the flag.
- R2: In variant 0 (plain), the result is bits 31:0 of the selected accumulator after an arithmetic right shift, sign-extended to 64 bits.
- R3: In variant 1 (rounding), the result adds 1 at the most significant discarded bit position before bits 31:0 are taken. For a shift of 0 there is no discarded bit, so the result equals the plain result.
- R4: In variant 2 (rounding and saturating), a rounded value that does not fit in 32 signed bits is clamped. It becomes 0x7FFFFFFF when it is positive and 0x80000000 when it is negative. Otherwise the result equals the rounded result.
- R5: Bit 23 of `ctrl_reg` is set when the shifted value, either before or after rounding, does not fit in 32 signed bits. This holds for every variant. The bit never clears except on reset, and every other bit of `ctrl_reg` reads 0.
- R6: Variant value 3 behaves exactly like variant 0.
- R7: `ext_acc_sel` picks accumulator 0 to 3, which are loaded through `acc_wr_*`. An extract never changes any accumulator.
- R8: `res_valid` is high in exactly the cycle after each cycle with `ext_valid` high. `res_data` and the flag update belong to that request.
- R9: When an accumulator write and an extract of the same accumulator happen in the same cycle, the extract uses the value from before the write.
- R10: A synchronous active-high `rst` clears all accumulators, `ctrl_reg` and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr_en | input | 1 | Accumulator write enable |
| acc_wr_sel | input | 2 | Accumulator written |
| acc_wr_data | input | 64 | Value written |
| ext_valid | input | 1 | Extract request strobe |
| ext_acc_sel | input | 2 | Accumulator extracted |
| shift_src | input | 64 | Shift-source value; low five bits used |
| ext_mode | input | 2 | 0 plain, 1 round, 2 round and saturate, 3 plain |
| res_valid | output | 1 | Result strobe, one cycle after request |
| res_data | output | 64 | Sign-extended extracted word |
| ctrl_reg | output | 32 | Control register; bit 23 sticky overflow flag |

## Verification
Every extract has a latency of exactly one clock, and this is true for `res_valid`, `res_data` and bit 23 of `ctrl_reg`. Accumulator writes take effect at the same edge as the request, so the value is visible to the following request. The bench keeps a behavioural model that takes in the same inputs at each rising edge and forms its expected outputs with that same one-edge delay. It then compares all three outputs with the model at every falling edge, which lies between the edge where the design updates and the next one. Overflow cases are placed after the flag-clear cases, because once the sticky bit is set it hides any later flag errors.

// File: rtl/acc_word_extract.sv
module acc_word_extract #(
  parameter int ACC_W    = 64,
  parameter int WORD_W   = 32,
  parameter int N_ACC    = 4,
  parameter int CTRL_W   = 32,
  parameter int FLAG_BIT = 23,
  parameter int SH_W     = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_wr_en,
  input  logic [$clog2(N_ACC)-1:0] acc_wr_sel,
  input  logic [ACC_W-1:0]         acc_wr_data,
  input  logic                     ext_valid,
  input  logic [$clog2(N_ACC)-1:0] ext_acc_sel,
  input  logic [ACC_W-1:0]         shift_src,
  input  logic [1:0]               ext_mode,
  output logic                     res_valid,
  output logic [ACC_W-1:0]         res_data,
  output logic [CTRL_W-1:0]        ctrl_reg
);
  localparam int TW = ACC_W + 1;
  localparam logic [WORD_W-1:0] POS_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] NEG_MAX = {1'b1, {(WORD_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_q [N_ACC];
  logic [ACC_W-1:0] acc_rd;
  logic [SH_W-1:0]  shamt;
  logic signed [TW-1:0] tmp;
  logic [TW-1:0]    tmp_rnd;
  logic             ovf_raw, ovf_rnd;
  logic [WORD_W-1:0] word;

  assign acc_rd  = acc_q[ext_acc_sel];
  assign shamt   = shift_src[SH_W-1:0];
  assign tmp     = $signed({acc_rd, 1'b0}) >>> shamt;
  assign tmp_rnd = tmp + 1'b1;

  assign ovf_raw = !((&tmp[TW-1:WORD_W])     || !(|tmp[TW-1:WORD_W]));
  assign ovf_rnd = !((&tmp_rnd[TW-1:WORD_W]) || !(|tmp_rnd[TW-1:WORD_W]));

  always_comb begin
    case (ext_mode)
      2'd1:    word = tmp_rnd[WORD_W:1];
      2'd2:    word = ovf_rnd ? (tmp_rnd[TW-1] ? NEG_MAX : POS_MAX)
                              : tmp_rnd[WORD_W:1];
      default: word = tmp[WORD_W:1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ACC; i++) acc_q[i] <= '0;
    end else if (acc_wr_en) begin
      acc_q[acc_wr_sel] <= acc_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      ctrl_reg  <= '0;
    end else begin
      res_valid <= ext_valid;
      if (ext_valid) begin
        res_data <= {{(ACC_W-WORD_W){word[WORD_W-1]}}, word};
        if (ovf_raw || ovf_rnd) ctrl_reg[FLAG_BIT] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/acc_word_extract_chk.sv
module acc_word_extract_chk #(
  parameter int ACC_W    = 64,
  parameter int WORD_W   = 32,
  parameter int CTRL_W   = 32,
  parameter int FLAG_BIT = 23
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_valid,
  input logic              res_valid,
  input logic [ACC_W-1:0]  res_data,
  input logic [CTRL_W-1:0] ctrl_reg
);
  logic [CTRL_W-1:0] other_mask;
  assign other_mask = ~(CTRL_W'(1) << FLAG_BIT);

  // R8
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    ext_valid |=> res_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !ext_valid |=> !res_valid);
  // R2
  a_r2_sign_ext: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_data[ACC_W-1:WORD_W] == {(ACC_W-WORD_W){res_data[WORD_W-1]}}));
  // R5
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    ctrl_reg[FLAG_BIT] |=> ctrl_reg[FLAG_BIT]);
  a_r5_rise_on_request: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_reg[FLAG_BIT]) |-> $past(ext_valid));
  a_r5_other_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (ctrl_reg & other_mask) == '0);
  // R10
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!res_valid && ctrl_reg == '0));
endmodule

bind acc_word_extract acc_word_extract_chk #(
  .ACC_W(ACC_W), .WORD_W(WORD_W), .CTRL_W(CTRL_W), .FLAG_BIT(FLAG_BIT)
) u_chk (
  .clk(clk), .rst(rst), .ext_valid(ext_valid), .res_valid(res_valid),
  .res_data(res_data), .ctrl_reg(ctrl_reg)
);

// File: tb/acc_word_extract_bench.sv
module acc_word_extract_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_wr_en = 1'b0;
  logic [1:0]  acc_wr_sel = '0;
  logic [63:0] acc_wr_data = '0;
  logic        ext_valid = 1'b0;
  logic [1:0]  ext_acc_sel = '0;
  logic [63:0] shift_src = '0;
  logic [1:0]  ext_mode = '0;
  logic        res_valid;
  logic [63:0] res_data;
  logic [31:0] ctrl_reg;

  always #2.5 clk = ~clk;

  acc_word_extract u_acc_word_extract (
    .clk(clk), .rst(rst), .acc_wr_en(acc_wr_en), .acc_wr_sel(acc_wr_sel),
    .acc_wr_data(acc_wr_data), .ext_valid(ext_valid), .ext_acc_sel(ext_acc_sel),
    .shift_src(shift_src), .ext_mode(ext_mode), .res_valid(res_valid),
    .res_data(res_data), .ctrl_reg(ctrl_reg)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R10";
  bit    done     = 1'b0;

  logic [63:0] m_acc [4];
  logic        m_valid;
  logic [63:0] m_data;
  logic        m_flag;

  function automatic logic [64:0] model(input logic [63:0] a, input int sh, input int mode);
    logic signed [65:0] v, r;
    logic d, o1, o2;
    logic [31:0] w;
    v = $signed({{2{a[63]}}, a}) >>> sh;
    d = (sh == 0) ? 1'b0 : a[sh-1];
    r = v + 66'(d);
    o1 = (v > 66'sd2147483647) || (v < -66'sd2147483648);
    o2 = (r > 66'sd2147483647) || (r < -66'sd2147483648);
    if (mode == 1) w = r[31:0];
    else if (mode == 2) w = o2 ? ((r < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF) : r[31:0];
    else w = v[31:0];
    return {o1 | o2, {{32{w[31]}}, w}};
  endfunction

  always @(posedge clk) begin
    logic [64:0] m;
    if (rst) begin
      for (int i = 0; i < 4; i++) m_acc[i] <= '0;
      m_valid <= 1'b0; m_data <= '0; m_flag <= 1'b0;
    end else begin
      m_valid <= ext_valid;
      if (ext_valid) begin
        m = model(m_acc[ext_acc_sel], int'(shift_src[4:0]), int'(ext_mode));
        m_data <= m[63:0];
        if (m[64]) m_flag <= 1'b1;
      end
      if (acc_wr_en) m_acc[acc_wr_sel] <= acc_wr_data;
    end
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(res_valid === m_valid, "res_valid", 64'(res_valid), 64'(m_valid));
      check(ctrl_reg === {8'h0, m_flag, 23'h0}, "ctrl_reg", 64'(ctrl_reg), 64'({8'h0, m_flag, 23'h0}));
      if (m_valid) check(res_data === m_data, "res_data", res_data, m_data);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    acc_wr_en = 1'b1; acc_wr_sel = s; acc_wr_data = d;
    @(negedge clk);
    acc_wr_en = 1'b0;
  endtask

  task automatic ex(input logic [1:0] s, input logic [63:0] sh, input logic [1:0] md);
    @(negedge clk);
    ext_valid = 1'b1; ext_acc_sel = s; shift_src = sh; ext_mode = md;
    @(negedge clk);
    ext_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: state straight after reset
    @(negedge clk);
    n_checks++;
    if (res_valid !== 1'b0 || ctrl_reg !== 32'h0) begin
      n_fail++;
      $display("FAIL R10 reset: actual %b/%h expected 0/0", res_valid, ctrl_reg);
    end
    cur_req = "R7"; ex(2'd3, 64'd0, 2'd0);
    cur_req = "R2";
    wr(2'd0, 64'h0000_0000_1234_5678);
    ex(2'd0, 64'd0, 2'd0);
    ex(2'd0, 64'd4, 2'd0);
    wr(2'd0, 64'hFFFF_FFFF_8765_4321);
    ex(2'd0, 64'd8, 2'd0);
    ex(2'd0, 64'd31, 2'd0);
    cur_req = "R1";
    ex(2'd0, 64'hFFFF_FFFF_FFFF_FFE8, 2'd0);
    ex(2'd0, 64'h8000_0000_0000_0003, 2'd1);
    cur_req = "R3";
    wr(2'd1, 64'h0000_0000_0000_00FF);
    ex(2'd1, 64'd4, 2'd1);
    ex(2'd1, 64'd0, 2'd1);
    wr(2'd1, 64'hFFFF_FFFF_FFFF_FF18);
    ex(2'd1, 64'd3, 2'd1);
    cur_req = "R6";
    ex(2'd1, 64'd3, 2'd3);
    cur_req = "R8";
    @(negedge clk);
    ext_valid = 1'b1; ext_acc_sel = 2'd0; shift_src = 64'd2; ext_mode = 2'd1;
    @(negedge clk);
    shift_src = 64'd5;
    @(negedge clk);
    ext_valid = 1'b0;
    cur_req = "R9";
    @(negedge clk);
    acc_wr_en = 1'b1; acc_wr_sel = 2'd2; acc_wr_data = 64'h0000_0000_0000_1000;
    ext_valid = 1'b1; ext_acc_sel = 2'd2; shift_src = 64'd4; ext_mode = 2'd0;
    @(negedge clk);
    acc_wr_en = 1'b0;
    @(negedge clk);
    ext_valid = 1'b0;
    cur_req = "R7";
    ex(2'd2, 64'd4, 2'd0);
    cur_req = "R4";
    wr(2'd3, 64'h0000_0000_7FFF_FFFF);
    ex(2'd3, 64'd0, 2'd2);
    wr(2'd3, 64'h0000_0000_FFFF_FFFF);
    ex(2'd3, 64'd1, 2'd2);
    wr(2'd3, 64'hFFFF_FF00_0000_0000);
    ex(2'd3, 64'd0, 2'd2);
    ex(2'd3, 64'd8, 2'd2);
    cur_req = "R5";
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    wr(2'd0, 64'h0000_0000_FFFF_FFFF);
    ex(2'd0, 64'd1, 2'd0);
    ex(2'd0, 64'd20, 2'd0);
    cur_req = "R10";
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    ex(2'd0, 64'd0, 2'd0);
    cur_req = "R2";
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      acc_wr_en   = ($urandom % 3) == 0;
      acc_wr_sel  = 2'($urandom);
      acc_wr_data = {$urandom, $urandom} >>> ($urandom % 40);
      ext_valid   = ($urandom % 4) != 0;
      ext_acc_sel = 2'($urandom);
      shift_src   = {$urandom, $urandom};
      ext_mode    = 2'($urandom);
    end
    @(negedge clk);
    acc_wr_en = 1'b0; ext_valid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule